// File: doc/BRIEF.md
# PCM Time-Slot Interchange Switch

This block is a memory-based time and space switch for framed serial PCM traffic. Sixteen serial input lines and eight serial output lines share one frame of 32 byte-wide time slots, sent MSB first at one bit per clock. Every byte of an input frame is kept in a speech store at a fixed location given by its slot and line. A per-output connection table then says, for each output slot on each output line, which input slot and line to copy from. Any of the 512 input channels can therefore reach any of the 256 output channels, and one input channel can feed several outputs at once.

The speech store is split into two halves by frame parity. One half fills with the current frame while the other half, holding the previous frame, is read out. Every routed byte therefore arrives exactly one frame late and is never a mix of two frames. Output slots with no connection drive a low output-enable, so several switches can share output wires. Connections are set through an 8-bit write-only port with three register selects.

Top module: `tsi_switch`

## Requirements
- R1: While reset is held, and after it is released, `oe_o` is all zeros and `out_o` is all ones. Every connection entry starts disabled, so every output slot stays idle until it is programmed.
- R2: A frame lasts 256 clocks: 32 slots of 8 bits. `frm_o` is high for exactly one clock at bit 0 of slot 0, and this first happens in the first clock after reset is released. Input line l carries its slot-s byte MSB first in clocks 8*s to 8*s+7 after `frm_o`.
- R3: Take an output slot t on output line o whose entry is enabled with source slot s on input line l. That output line drives the byte received on line l in slot s of the previous frame, MSB first, with `oe_o` high. It does so in clocks 8*(t+1) to 8*(t+1)+7 of the current frame; slot 31 instead uses clocks 0 to 7 of the next frame. `oe_o` changes only at slot boundaries.
- R4: An output slot whose entry is disabled holds `oe_o` low and `out_o` high for all 8 of its clocks.
- R5: Write port layout:
  - `cpu_addr`=0 latches the destination: output slot in data bits 7:3, output line in bits 2:0.
  - `cpu_addr`=1 latches the low source part: input slot bits 3:0 in data bits 7:4, input line in bits 3:0.
  - `cpu_addr`=2 writes the entry at the latched destination. Data bit 0 is input slot bit 4 and data bit 1 is the enable.
  - The entry for output slot t is looked up in the last clock of input slot t (clock 8*t+7), so the lookup sees every commit made in an earlier clock.
- R6: A write with `cpu_addr`=3 changes neither the latched destination, nor the latched source, nor any entry.
- R7: One input channel may be routed to several output slots and lines in the same frame, and each of them carries the same byte.
- R8: Committing to a destination that already has an entry replaces that entry. Later frames carry the new source, or go idle if the new entry is disabled.
- R9: A route from input slot 31 to output slot 0 delivers the whole slot-31 byte of the previous frame, even though that byte is stored only during the first clocks of the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per line per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_i | input | 16 | Serial input lines, MSB first |
| frm_o | output | 1 | High at bit 0 of slot 0 of each frame |
| out_o | output | 8 | Serial output lines, MSB first, idle high |
| oe_o | output | 8 | Per-line output enable, high while a routed byte is driven |
| cpu_we | input | 1 | Write strobe of the configuration port |
| cpu_addr | input | 2 | Register select of the configuration port |
| cpu_data | input | 8 | Write data of the configuration port |

## Verification
The hardest case is the seam between frames. A byte taken in input slot 31 is stored during the first clocks of the next frame, and it is read from the same half a few clocks later for output slot 0. Commits that land while the table is being swept also change what the following lookups see. The bench drives a deterministic byte pattern that depends on frame, slot and line, and programs routes through the write port while traffic is already running. Its model applies each commit in the same clock the switch does. It covers the slot-31-to-slot-0 route, a route into output slot 31 that spills into the next frame, a broadcast, a reprogram and a disconnect. Writes with `cpu_addr`=3 are placed between the real register writes.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    typedef enum logic [1:0] {
        SEL_DEST   = 2'd0,
        SEL_SRC    = 2'd1,
        SEL_COMMIT = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/tsi_capture.sv
module tsi_capture #(
    parameter int N_IN     = 16,
    parameter int BYTE_W   = 8,
    parameter int SLOTS    = 32,
    parameter int WR_LANES = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [$clog2(BYTE_W)-1:0]             bit_idx,
    input  logic [$clog2(SLOTS)-1:0]              slot_idx,
    input  logic                                  par,
    input  logic [N_IN-1:0]                       in_i,
    output logic                                  wr_en,
    output logic                                  wr_par,
    output logic [$clog2(SLOTS)-1:0]              wr_slot,
    output logic [$clog2(N_IN)-1:0]               wr_base,
    output logic [WR_LANES-1:0][BYTE_W-1:0]       wr_data
);
    localparam int BC_W   = $clog2(BYTE_W);
    localparam int SL_W   = $clog2(SLOTS);
    localparam int IL_W   = $clog2(N_IN);
    localparam int WR_CYC = N_IN / WR_LANES;

    typedef struct packed {
        logic [N_IN-1:0][BYTE_W-1:0] sh;
        logic [N_IN-1:0][BYTE_W-1:0] hold;
        logic [SL_W-1:0]             hslot;
        logic                        hpar;
        logic                        hvld;
    } cap_t;

    cap_t cap_d, cap_q;

    // Shift in every line; snapshot all lines when a slot completes.
    always_comb begin
        cap_d = cap_q;
        for (int l = 0; l < N_IN; l++) begin
            cap_d.sh[l] = {cap_q.sh[l][BYTE_W-2:0], in_i[l]};
        end
        if (bit_idx == BC_W'(BYTE_W - 1)) begin
            cap_d.hold  = cap_d.sh;
            cap_d.hslot = slot_idx;
            cap_d.hpar  = par;
            cap_d.hvld  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    // Drain the snapshot into the speech store, WR_LANES lines per cycle,
    // lowest line numbers first, during the first WR_CYC bits of the slot.
    assign wr_en   = cap_q.hvld && (int'(bit_idx) < WR_CYC);
    assign wr_par  = cap_q.hpar;
    assign wr_slot = cap_q.hslot;
    assign wr_base = IL_W'(int'(bit_idx) * WR_LANES);

    always_comb begin
        for (int k = 0; k < WR_LANES; k++) begin
            wr_data[k] = cap_q.hold[wr_base + IL_W'(k)];
        end
    end

endmodule

// File: rtl/tsi_speech_mem.sv
module tsi_speech_mem #(
    parameter int N_IN     = 16,
    parameter int N_OUT    = 8,
    parameter int SLOTS    = 32,
    parameter int BYTE_W   = 8,
    parameter int WR_LANES = 4
) (
    input  logic                                              clk,
    input  logic                                              wr_en,
    input  logic                                              wr_par,
    input  logic [$clog2(SLOTS)-1:0]                          wr_slot,
    input  logic [$clog2(N_IN)-1:0]                           wr_base,
    input  logic [WR_LANES-1:0][BYTE_W-1:0]                   wr_data,
    input  logic [N_OUT-1:0][$clog2(SLOTS)+$clog2(N_IN):0]    rd_addr,
    output logic [N_OUT-1:0][BYTE_W-1:0]                      rd_data
);
    localparam int IL_W  = $clog2(N_IN);
    localparam int DEPTH = 2 * SLOTS * N_IN;

    // Two frame halves selected by the address MSB (frame parity).
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < WR_LANES; k++) begin
                mem[{wr_par, wr_slot, IL_W'(wr_base + IL_W'(k))}] <= wr_data[k];
            end
        end
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            rd_data[o] = mem[rd_addr[o]];
        end
    end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int N_OUT = 8,
    parameter int SLOTS = 32
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       cpu_we,
    input  logic [1:0]                                 cpu_addr,
    input  logic [7:0]                                 cpu_data,
    input  logic [$clog2(SLOTS)-1:0]                   rd_slot,
    output logic [N_OUT-1:0]                           rd_en,
    output logic [N_OUT-1:0][$clog2(SLOTS)-1:0]        rd_src_slot,
    output logic [N_OUT-1:0][$clog2(N_IN)-1:0]         rd_src_line
);
    localparam int SL_W     = $clog2(SLOTS);
    localparam int IL_W     = $clog2(N_IN);
    localparam int OL_W     = $clog2(N_OUT);
    localparam int CM_AW    = SL_W + OL_W;
    localparam int CM_DEPTH = SLOTS * N_OUT;
    localparam int SRC_W    = SL_W + IL_W;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
    } route_t;

    typedef struct packed {
        logic [CM_AW-1:0] dest;
        logic [7:0]       src_lo;
    } regs_t;

    regs_t  rg_d, rg_q;
    logic   commit;
    route_t new_rt;

    always_comb begin
        rg_d   = rg_q;
        commit = 1'b0;
        new_rt = '0;
        if (cpu_we) begin
            case (reg_sel_e'(cpu_addr))
                SEL_DEST:   rg_d.dest   = CM_AW'(cpu_data);
                SEL_SRC:    rg_d.src_lo = cpu_data;
                SEL_COMMIT: begin
                    commit     = 1'b1;
                    new_rt.en  = cpu_data[1];
                    new_rt.src = SRC_W'({cpu_data[0], rg_q.src_lo});
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    route_t cm_q [CM_DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CM_DEPTH; i++) begin
                cm_q[i] <= '0;
            end
        end else if (commit) begin
            cm_q[rg_q.dest] <= new_rt;
        end
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            route_t r;
            r              = cm_q[{rd_slot, OL_W'(o)}];
            rd_en[o]       = r.en;
            rd_src_slot[o] = r.src[SRC_W-1 -: SL_W];
            rd_src_line[o] = r.src[IL_W-1:0];
        end
    end

endmodule

// File: rtl/tsi_out_serial.sv
module tsi_out_serial #(
    parameter int N_OUT  = 8,
    parameter int BYTE_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [$clog2(BYTE_W)-1:0]         bit_idx,
    input  logic [N_OUT-1:0]                  ld_en,
    input  logic [N_OUT-1:0][BYTE_W-1:0]      ld_data,
    output logic [N_OUT-1:0]                  out_o,
    output logic [N_OUT-1:0]                  oe_o
);
    localparam int BC_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [N_OUT-1:0][BYTE_W-1:0] sh;
        logic [N_OUT-1:0]             oe;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        for (int o = 0; o < N_OUT; o++) begin
            if (bit_idx == BC_W'(BYTE_W - 1)) begin
                ser_d.sh[o] = ld_en[o] ? ld_data[o] : '1;
                ser_d.oe[o] = ld_en[o];
            end else begin
                ser_d.sh[o] = {ser_q.sh[o][BYTE_W-2:0], 1'b1};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q.sh <= '1;
            ser_q.oe <= '0;
        end else begin
            ser_q <= ser_d;
        end
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            out_o[o] = ser_q.sh[o][BYTE_W-1];
        end
    end
    assign oe_o = ser_q.oe;

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int N_IN     = 16,
    parameter int N_OUT    = 8,
    parameter int SLOTS    = 32,
    parameter int BYTE_W   = 8,
    parameter int WR_LANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   in_i,
    output logic              frm_o,
    output logic [N_OUT-1:0]  out_o,
    output logic [N_OUT-1:0]  oe_o,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_addr,
    input  logic [7:0]        cpu_data
);
    localparam int SL_W  = $clog2(SLOTS);
    localparam int IL_W  = $clog2(N_IN);
    localparam int BC_W  = $clog2(BYTE_W);
    localparam int SM_AW = 1 + SL_W + IL_W;

    typedef struct packed {
        logic            par;
        logic [SL_W-1:0] slot;
        logic [BC_W-1:0] bitc;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (tm_q.bitc == BC_W'(BYTE_W - 1)) begin
            tm_d.bitc = '0;
            if (tm_q.slot == SL_W'(SLOTS - 1)) begin
                tm_d.slot = '0;
                tm_d.par  = ~tm_q.par;
            end else begin
                tm_d.slot = tm_q.slot + 1'b1;
            end
        end else begin
            tm_d.bitc = tm_q.bitc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    logic [BC_W-1:0] bit_idx;
    assign bit_idx = tm_q.bitc;
    assign frm_o   = (tm_q.slot == '0) && (tm_q.bitc == '0);

    logic                               sm_wr_en;
    logic                               sm_wr_par;
    logic [SL_W-1:0]                    sm_wr_slot;
    logic [IL_W-1:0]                    sm_wr_base;
    logic [WR_LANES-1:0][BYTE_W-1:0]    sm_wr_data;
    logic [N_OUT-1:0]                   rt_en;
    logic [N_OUT-1:0][SL_W-1:0]         rt_slot;
    logic [N_OUT-1:0][IL_W-1:0]         rt_line;
    logic [N_OUT-1:0][SM_AW-1:0]        sm_rd_addr;
    logic [N_OUT-1:0][BYTE_W-1:0]       sm_rd_data;

    tsi_capture #(
        .N_IN(N_IN), .BYTE_W(BYTE_W), .SLOTS(SLOTS), .WR_LANES(WR_LANES)
    ) cap_i (
        .clk(clk), .rst_n(rst_n), .bit_idx(bit_idx), .slot_idx(tm_q.slot),
        .par(tm_q.par), .in_i(in_i), .wr_en(sm_wr_en), .wr_par(sm_wr_par),
        .wr_slot(sm_wr_slot), .wr_base(sm_wr_base), .wr_data(sm_wr_data)
    );

    tsi_conn_mem #(
        .N_IN(N_IN), .N_OUT(N_OUT), .SLOTS(SLOTS)
    ) cm_i (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .rd_slot(tm_q.slot), .rd_en(rt_en),
        .rd_src_slot(rt_slot), .rd_src_line(rt_line)
    );

    // Read the half that holds the previous, complete frame.
    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            sm_rd_addr[o] = {~tm_q.par, rt_slot[o], rt_line[o]};
        end
    end

    tsi_speech_mem #(
        .N_IN(N_IN), .N_OUT(N_OUT), .SLOTS(SLOTS), .BYTE_W(BYTE_W),
        .WR_LANES(WR_LANES)
    ) sm_i (
        .clk(clk), .wr_en(sm_wr_en), .wr_par(sm_wr_par), .wr_slot(sm_wr_slot),
        .wr_base(sm_wr_base), .wr_data(sm_wr_data), .rd_addr(sm_rd_addr),
        .rd_data(sm_rd_data)
    );

    tsi_out_serial #(
        .N_OUT(N_OUT), .BYTE_W(BYTE_W)
    ) ser_i (
        .clk(clk), .rst_n(rst_n), .bit_idx(bit_idx), .ld_en(rt_en),
        .ld_data(sm_rd_data), .out_o(out_o), .oe_o(oe_o)
    );

endmodule

module tsi_switch_chk #(
    parameter int N_OUT  = 8,
    parameter int BYTE_W = 8,
    parameter int FRAME  = 256
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        frm_o,
    input logic [N_OUT-1:0]            out_o,
    input logic [N_OUT-1:0]            oe_o,
    input logic [$clog2(BYTE_W)-1:0]   bit_idx
);
    logic [31:0] gap;
    logic        seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (frm_o) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    // R2
    frm_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_o && seen) |-> (gap == 32'(FRAME - 1)));

    // R2
    frm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_o |=> !frm_o);

    // R3
    oe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx != '0) |-> $stable(oe_o));

    // R4
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~oe_o & ~out_o) == '0));

endmodule

bind tsi_switch tsi_switch_chk #(
    .N_OUT(N_OUT), .BYTE_W(BYTE_W), .FRAME(SLOTS * BYTE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .frm_o(frm_o), .out_o(out_o), .oe_o(oe_o),
    .bit_idx(bit_idx)
);

// File: tb/tsi_switch_tb_top.sv
module tsi_switch_tb_top;
    localparam int N_IN  = 16;
    localparam int N_OUT = 8;
    localparam int SLOTS = 32;
    localparam int FRAME = SLOTS * 8;
    localparam int NFR   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_IN-1:0]  in_i = '0;
    logic             frm_o;
    logic [N_OUT-1:0] out_o;
    logic [N_OUT-1:0] oe_o;
    logic             cpu_we = 1'b0;
    logic [1:0]       cpu_addr = '0;
    logic [7:0]       cpu_data = '0;

    always #5 clk = ~clk;

    tsi_switch dut_i (
        .clk(clk), .rst_n(rst_n), .in_i(in_i), .frm_o(frm_o), .out_o(out_o),
        .oe_o(oe_o), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_data(cpu_data)
    );

    typedef struct {
        bit         en;
        bit [7:0]   data;
        bit         chk_data;
        string      tag;
        int         t;
        int         o;
    } exp_t;

    typedef struct {
        bit [1:0] a;
        bit [7:0] d;
        string    tag;
    } op_t;

    exp_t  exp_q[$];
    op_t   op_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    bit    cm_en  [SLOTS][N_OUT];
    int    cm_s   [SLOTS][N_OUT];
    int    cm_l   [SLOTS][N_OUT];
    string cm_tag [SLOTS][N_OUT];
    bit [7:0] m_dest = '0;
    bit [7:0] m_src  = '0;

    bit [7:0] got_bits [N_OUT];
    bit       got_oe   [N_OUT];
    bit       oe_bad   [N_OUT];

    function automatic bit [7:0] byte_of(int f, int s, int l);
        return 8'((f * 73 + s * 29 + l * 151 + s * l * 3) ^ 8'h5a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Queue the register writes for one route; bad=1 mixes in writes to select 3.
    task automatic conn(input int t, input int o, input int s, input int l,
                        input bit en, input string tag, input bit bad);
        op_t op;
        op.tag = tag;
        op.a = 2'd0; op.d = {t[4:0], o[2:0]}; op_q.push_back(op);
        if (bad) begin op.a = 2'd3; op.d = 8'h4e; op_q.push_back(op); end
        op.a = 2'd1; op.d = {s[3:0], l[3:0]}; op_q.push_back(op);
        if (bad) begin op.a = 2'd3; op.d = 8'h3f; op_q.push_back(op); end
        op.a = 2'd2; op.d = {6'd0, en, s[4]}; op_q.push_back(op);
    endtask

    task automatic apply_op(input op_t op);
        int t, o;
        case (op.a)
            2'd0: m_dest = op.d;
            2'd1: m_src  = op.d;
            2'd2: begin
                t = int'(m_dest[7:3]);
                o = int'(m_dest[2:0]);
                cm_en[t][o]  = op.d[1];
                cm_s[t][o]   = int'({op.d[0], m_src[7:4]});
                cm_l[t][o]   = int'(m_src[3:0]);
                cm_tag[t][o] = op.tag;
            end
            default: ; // R6: select 3 ignored by the model
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        exp_t e;
        for (int t = 0; t < SLOTS; t++) begin
            for (int o = 0; o < N_OUT; o++) begin
                cm_en[t][o] = 0; cm_s[t][o] = 0; cm_l[t][o] = 0;
                cm_tag[t][o] = "R1";
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle state during reset
        chk(oe_o == '0, "R1", "oe during reset", int'(oe_o), 0);
        chk(out_o == '1, "R1", "out during reset", int'(out_o), 8'hff);
        // R1: slot shown right after release is idle
        for (int o = 0; o < N_OUT; o++) begin
            e.en = 0; e.data = 8'hff; e.chk_data = 0; e.tag = "R1"; e.t = 31; e.o = o;
            exp_q.push_back(e);
        end
        rst_n = 1'b1;

        for (int p = 0; p < NFR * FRAME; p++) begin
            int f, s, b;
            f = p / FRAME;
            s = (p / 8) % SLOTS;
            b = p % 8;

            if (p == 0) begin
                conn(0, 0, 5, 3, 1, "R3", 0);
                conn(0, 1, 31, 2, 1, "R9", 0);
                conn(31, 7, 30, 15, 1, "R5", 0);
                conn(4, 2, 12, 9, 1, "R7", 0);
                conn(4, 5, 12, 9, 1, "R7", 0);
                conn(20, 3, 12, 9, 1, "R7", 0);
                conn(8, 4, 19, 1, 1, "R6", 1);
                conn(17, 6, 0, 0, 1, "R3", 0);
            end
            if (p == 4 * FRAME) begin
                conn(0, 0, 7, 14, 1, "R8", 0);
                conn(4, 2, 12, 9, 0, "R4", 0);
                conn(13, 4, 2, 11, 1, "R6", 1);
            end

            // ---- monitor: frame marker (R2)
            if (p % FRAME == 0 || frm_o)
                chk(frm_o == (p % FRAME == 0), "R2", "frame marker",
                    int'(frm_o), int'(p % FRAME == 0));

            // ---- monitor: collect one output slot and compare (scoreboard)
            for (int o = 0; o < N_OUT; o++) begin
                if (b == 0) begin
                    got_oe[o] = oe_o[o];
                    oe_bad[o] = 0;
                end else if (oe_o[o] != got_oe[o]) begin
                    oe_bad[o] = 1;
                end
                got_bits[o] = {got_bits[o][6:0], out_o[o]};
            end
            if (b == 7) begin
                for (int o = 0; o < N_OUT; o++) begin
                    bit ok;
                    bit [7:0] want;
                    e = exp_q.pop_front();
                    want = e.en ? e.data : 8'hff;
                    ok = !oe_bad[o] && (got_oe[o] == e.en) &&
                         (!(e.en && !e.chk_data) ? (got_bits[o] == want) : 1'b1);
                    chk(ok, e.tag, $sformatf("frame %0d out slot %0d line %0d oe=%0d",
                        f, e.t, e.o, got_oe[o]), int'(got_bits[o]), int'(want));
                end
            end

            // ---- driver: input bits of this position
            for (int l = 0; l < N_IN; l++) begin
                bit [7:0] v;
                v = byte_of(f, s, l);
                in_i[l] = v[7 - b];
            end

            // ---- driver: lookup for output slot s happens now (R5 timing)
            if (b == 7) begin
                for (int o = 0; o < N_OUT; o++) begin
                    e.en = cm_en[s][o];
                    e.chk_data = (f >= 1);
                    e.data = (f >= 1) ? byte_of(f - 1, cm_s[s][o], cm_l[s][o]) : 8'h00;
                    e.tag = cm_en[s][o] ? cm_tag[s][o] :
                            ((cm_tag[s][o] == "R1") ? "R1" : "R4");
                    e.t = s;
                    e.o = o;
                    exp_q.push_back(e);
                end
            end

            // ---- driver: configuration port, one write per clock
            if (op_q.size() > 0) begin
                op_t op;
                op = op_q.pop_front();
                cpu_we   = 1'b1;
                cpu_addr = op.a;
                cpu_data = op.d;
                apply_op(op);
            end else begin
                cpu_we   = 1'b0;
                cpu_addr = 2'd0;
                cpu_data = 8'd0;
            end

            @(posedge clk);
            @(negedge clk);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule